// File: doc/BRIEF.md
# Strobed input port handshake

This block is one 8-bit parallel input port working in strobed (latched) mode. A peripheral puts a byte on the port pins and pulses an active-low strobe. The port captures the byte on the strobe, raises an input-buffer-full flag, and asks the CPU for service with an interrupt request once the strobe has gone back high. The CPU then reads the captured byte with an active-low read. The read takes the interrupt request down when it begins and clears the buffer-full flag when it ends.

The interrupt request is gated by an enable flip-flop. Software reaches that flip-flop only through a port C bit set/reset write. The bit number is a parameter: 4 for the first port of a pair and 2 for the second. The buffer-full flag and the interrupt request are the handshake lines that go out on the port's control/status half of port C. Both pins, strobe and read, are asynchronous to the block clock. Each passes through a flop synchroniser before its edges are detected. When the port is taken out of strobed mode, its handshake state is cleared.

Top module: `strobed_in_port`

## Requirements
- R1: While `rst` is high, and in the first cycle after it, `ibf` and `intr` are 0 and `rd_data` is 0.
- R2: The port input is captured into `rd_data` on the synchronised falling edge of `strobe_n`, and the new value is visible 3 clock edges after the pin falls. Later changes on `port_in` do not change `rd_data` until the next strobe.
- R3: `ibf` is set 3 clock edges after `strobe_n` falls. It stays set until the synchronised rising edge of `rd_n` and is 0 three edges after that edge.
- R4: `intr` is 1 only while the synchronised strobe is high, `ibf` is 1 and the interrupt enable is 1. It rises 3 edges after `strobe_n` returns high and stays 0 while the strobe is low.
- R5: `intr` falls 3 edges after `rd_n` falls, while `ibf` is still 1. It does not come back for the rest of that read.
- R6: A strobe that arrives while `ibf` is 1 replaces `rd_data` with the new byte and leaves `ibf` at 1.
- R7: A write with `bsr_we` high and `bsr_bit` equal to `INTE_BIT` (default 4) loads `bsr_val` into the interrupt enable. A write with any other bit number has no effect on `intr`.
- R8: With the interrupt enable at 0, `intr` stays 0 through a complete strobe and read.
- R9: When `strobed_mode` is 0, `ibf`, `intr` and the interrupt enable are cleared one edge later. Strobes and bit set/reset writes made while `strobed_mode` is 0 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| strobed_mode | input | 1 | 1 while the port is configured for strobed input |
| port_in | input | DW | Data pins from the peripheral |
| strobe_n | input | 1 | Peripheral strobe, active low, asynchronous |
| rd_n | input | 1 | CPU read of this port, active low, asynchronous |
| bsr_we | input | 1 | Port C bit set/reset write pulse |
| bsr_bit | input | SELW | Port C bit number of the set/reset write |
| bsr_val | input | 1 | Value written to the selected bit |
| rd_data | output | DW | Captured byte presented to the CPU |
| ibf | output | 1 | Input buffer full handshake line |
| intr | output | 1 | Interrupt request to the CPU |

## Verification
Each pin change passes through two synchroniser flops and one output register. A change on `strobe_n` or `rd_n` therefore reaches `ibf`, `rd_data` or `intr` on the third clock edge after it. A bit set/reset write reaches `intr` one edge after the write edge, and leaving strobed mode clears the flags on the next edge. The bench drives every input a quarter period after a rising edge. It waits the exact number of edges for each result and samples a quarter period after that edge. For a few cases it also samples one edge early, to show the result is not there yet. The byte sweep covers all 256 values, with the enable set and then with the enable clear.

// File: rtl/strobed_in_port.sv
module strobed_in_port #(
  parameter int DW = 8,
  parameter int PC_BITS = 8,
  parameter int INTE_BIT = 4,
  parameter int SYNC_STAGES = 2,
  localparam int SELW = $clog2(PC_BITS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          strobed_mode,
  input  logic [DW-1:0] port_in,
  input  logic          strobe_n,
  input  logic          rd_n,
  input  logic          bsr_we,
  input  logic [SELW-1:0] bsr_bit,
  input  logic          bsr_val,
  output logic [DW-1:0] rd_data,
  output logic          ibf,
  output logic          intr
);

  localparam logic [SELW-1:0] IE_SEL = SELW'(INTE_BIT);

  logic [SYNC_STAGES-1:0] stb_sync, rd_sync;
  logic stb_s, rd_s, stb_q, rd_q;
  logic stb_fall, rd_rise;
  logic inte;
  logic intr_set;
  logic [DW-1:0] data_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      stb_sync <= '1;
      rd_sync  <= '1;
      stb_q    <= 1'b1;
      rd_q     <= 1'b1;
    end else begin
      stb_sync <= {stb_sync[SYNC_STAGES-2:0], strobe_n};
      rd_sync  <= {rd_sync[SYNC_STAGES-2:0], rd_n};
      stb_q    <= stb_s;
      rd_q     <= rd_s;
    end
  end

  assign stb_s    = stb_sync[SYNC_STAGES-1];
  assign rd_s     = rd_sync[SYNC_STAGES-1];
  assign stb_fall = stb_q & ~stb_s;
  assign rd_rise  = ~rd_q & rd_s;

  always_ff @(posedge clk) begin
    if (rst)
      inte <= 1'b0;
    else if (!strobed_mode)
      inte <= 1'b0;
    else if (bsr_we && bsr_bit == IE_SEL)
      inte <= bsr_val;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      data_q <= '0;
      ibf    <= 1'b0;
    end else if (!strobed_mode) begin
      ibf <= 1'b0;
    end else if (stb_fall) begin
      data_q <= port_in;
      ibf    <= 1'b1;
    end else if (rd_rise) begin
      ibf <= 1'b0;
    end
  end

  assign intr_set = inte & ibf & stb_s & rd_s & ~rd_rise;

  always_ff @(posedge clk) begin
    if (rst || !strobed_mode)
      intr <= 1'b0;
    else
      intr <= intr_set;
  end

  assign rd_data = data_q;

endmodule

module strobed_in_port_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          strobed_mode,
  input logic          rd_n,
  input logic          stb_fall,
  input logic          rd_rise,
  input logic          inte,
  input logic [DW-1:0] rd_data,
  input logic          ibf,
  input logic          intr
);

  // R4
  intr_needs_ibf_chk: assert property (@(posedge clk) disable iff (rst)
    intr |-> ibf);

  // R9
  mode_off_clear_chk: assert property (@(posedge clk) disable iff (rst)
    !strobed_mode |=> (!ibf && !intr));

  // R5
  read_drops_intr_chk: assert property (@(posedge clk) disable iff (rst)
    (!rd_n && !$past(rd_n) && !$past(rd_n, 2) && !$past(rd_n, 3)) |-> !intr);

  // R3
  ibf_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (ibf && !rd_rise && strobed_mode) |=> ibf);

  // R8
  inte_gate_chk: assert property (@(posedge clk) disable iff (rst)
    !inte |=> !intr);

  // R2
  data_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !stb_fall |=> $stable(rd_data));

endmodule

bind strobed_in_port strobed_in_port_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst(rst), .strobed_mode(strobed_mode), .rd_n(rd_n),
  .stb_fall(stb_fall), .rd_rise(rd_rise), .inte(inte),
  .rd_data(rd_data), .ibf(ibf), .intr(intr)
);

// File: tb/test_strobed_in_port.sv
module test_strobed_in_port;
  localparam int CLK_PER = 10;
  localparam int DW = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic strobed_mode = 1'b0;
  logic [DW-1:0] port_in = '0;
  logic strobe_n = 1'b1;
  logic rd_n = 1'b1;
  logic bsr_we = 1'b0;
  logic [2:0] bsr_bit = '0;
  logic bsr_val = 1'b0;
  logic [DW-1:0] rd_data;
  logic ibf, intr;

  int n_chk = 0;
  int n_fail = 0;
  logic done = 1'b0;

  always #(CLK_PER/2) clk = ~clk;

  strobed_in_port i_strobed_in_port (
    .clk(clk), .rst(rst), .strobed_mode(strobed_mode), .port_in(port_in),
    .strobe_n(strobe_n), .rd_n(rd_n), .bsr_we(bsr_we), .bsr_bit(bsr_bit),
    .bsr_val(bsr_val), .rd_data(rd_data), .ibf(ibf), .intr(intr)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #(CLK_PER/4);
  endtask

  task automatic bsr(input int b, input logic v);
    bsr_we = 1'b1; bsr_bit = 3'(b); bsr_val = v;
    cyc(1);
    bsr_we = 1'b0;
  endtask

  task automatic strobe(input logic [DW-1:0] v, input logic en);
    port_in = v; strobe_n = 1'b0;
    cyc(3);
    check("R3 ibf after strobe", ibf, 1);
    check("R2 data captured", rd_data, v);
    check("R4 intr low while strobe low", intr, 0);
    strobe_n = 1'b1; port_in = ~v;
    cyc(3);
    check("R4 intr after strobe high", intr, en);
    check("R2 data held", rd_data, v);
  endtask

  task automatic read_cycle(input logic [DW-1:0] v);
    rd_n = 1'b0;
    cyc(3);
    check("R5 intr cleared by read", intr, 0);
    check("R3 ibf held during read", ibf, 1);
    check("R2 read data", rd_data, v);
    rd_n = 1'b1;
    cyc(3);
    check("R3 ibf cleared after read", ibf, 0);
    check("R5 intr stays low", intr, 0);
  endtask

  initial begin
    cyc(3);
    check("R1 reset ibf", ibf, 0);
    check("R1 reset intr", intr, 0);
    check("R1 reset data", rd_data, 0);
    rst = 1'b0;
    cyc(1);
    check("R1 ibf after reset", ibf, 0);
    check("R1 intr after reset", intr, 0);
    strobed_mode = 1'b1;
    cyc(1);

    for (int b = 0; b < 8; b++) begin
      if (b != 4) bsr(b, 1'b1);
    end
    strobe(8'h3c, 1'b0);
    check("R7 other bsr bits ignored", intr, 0);
    read_cycle(8'h3c);

    bsr(4, 1'b1);
    port_in = 8'h81; strobe_n = 1'b0;
    cyc(2);
    check("R3 ibf not before third edge", ibf, 0);
    cyc(1);
    check("R3 ibf on third edge", ibf, 1);
    strobe_n = 1'b1;
    cyc(2);
    check("R4 intr not before third edge", intr, 0);
    cyc(1);
    check("R4 intr on third edge", intr, 1);
    rd_n = 1'b0;
    cyc(2);
    check("R5 intr not yet cleared", intr, 1);
    cyc(1);
    check("R5 intr cleared on third edge", intr, 0);
    rd_n = 1'b1;
    cyc(3);
    check("R3 ibf cleared", ibf, 0);

    for (int v = 0; v < 256; v++) begin
      strobe(8'(v), 1'b1);
      read_cycle(8'(v));
    end

    strobe(8'h11, 1'b1);
    strobe(8'h22, 1'b1);
    check("R6 overwrite keeps ibf", ibf, 1);
    check("R6 overwrite data", rd_data, 8'h22);
    read_cycle(8'h22);

    bsr(2, 1'b0);
    strobe(8'h5a, 1'b1);
    check("R7 clearing other bit kept enable", intr, 1);
    read_cycle(8'h5a);

    bsr(4, 1'b0);
    for (int v = 0; v < 256; v += 17) begin
      strobe(8'(v), 1'b0);
      check("R8 no intr when disabled", intr, 0);
      read_cycle(8'(v));
    end

    bsr(4, 1'b1);
    strobe(8'h77, 1'b1);
    strobed_mode = 1'b0;
    cyc(1);
    check("R9 mode exit clears ibf", ibf, 0);
    check("R9 mode exit clears intr", intr, 0);
    bsr(4, 1'b1);
    port_in = 8'hee; strobe_n = 1'b0;
    cyc(4);
    check("R9 strobe ignored ibf", ibf, 0);
    check("R9 strobe ignored data", rd_data, 8'h77);
    strobe_n = 1'b1;
    cyc(4);
    strobed_mode = 1'b1;
    cyc(1);
    strobe(8'h99, 1'b0);
    check("R9 enable cleared by mode exit", intr, 0);
    read_cycle(8'h99);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule